// File: doc/BRIEF.md
# Ramped Step-Pulse Generator

This block drives one motor axis with a train of single-cycle step pulses. The pulse rate comes from a phase accumulator that is advanced on every tick of a programmable prescaler. A ramp engine moves the rate in both directions between a start rate and a run rate. The engine updates the rate on a fixed grid of acceleration ticks. The rate can follow a straight line, or an S-curve built from two parabolic halves.

A host loads the prescaler divisor, both rates, an acceleration code, a pulse budget and a ramp-down threshold through a small write port. It then issues one of three commands: start, halt at once, or slow down and stop. In budget mode the block counts the pulses it emits. It starts to slow down when the remaining count falls to the threshold, and stops when the budget is used up. Two held levels, ramp-down reached and stopped, are intended for an interrupt controller. A start command clears both levels.

Top module: `stepramp_gen`

## Requirements
- R1: Once reset is released, step_out, busy, rdn_level and halt_level are all low.
- R2: With a constant rate value N, step pulses are one cycle wide and repeat every max(div,2)·8192/N clock cycles, whenever N divides 8192. A divisor below 2 acts as 2.
- R3: A start raises busy on the next cycle. The rate begins at the start rate. If the run rate does not exceed the start rate, the axis stays at the start rate.
- R4: In linear mode the rate changes by one unit once every max(acc,1) clock cycles. A full ramp across D units therefore lasts D·max(acc,1) cycles, and the axis then holds the run rate.
- R5: In S-curve mode (mode bit 0 = 1) a ramp across D units lasts 2·D·max(acc,1) cycles, twice the linear time for the same settings.
- R6: In budget mode (mode bit 1 = 1) exactly the loaded number of pulses is emitted. halt_level rises and busy falls in the same cycle as the last pulse, and no pulse follows.
- R7: In budget mode rdn_level rises one cycle after the pulse that leaves the remaining count equal to the threshold. At that point the pulse count is budget minus threshold. The level then holds while the axis decelerates.
- R8: A halt command (code 2) stops the axis. A pulse generated in the same cycle as the command is still emitted, no later pulse follows, and halt_level rises.
- R9: A slow-down command (code 3) ramps the rate back to the start rate, then stops and raises halt_level.
- R10: A start command (code 1) clears halt_level and rdn_level. A halt command while idle has no effect.
- R11: A start in budget mode with a zero budget emits no pulse. halt_level is high on the next cycle and busy stays low.
- R12: Register addresses on cfg_addr: 0 prescaler divisor, 1 start rate, 2 run rate, 3 acceleration code, 4 pulse budget, 5 ramp-down threshold, 6 mode. Command code 0 means no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | CNT_W | Register write data |
| cmd_code | input | 2 | Command: 0 none, 1 start, 2 halt, 3 slow-down |
| step_out | output | 1 | Step pulse, one cycle wide |
| busy | output | 1 | Axis is moving |
| rdn_level | output | 1 | Ramp-down threshold reached, held until next start |
| halt_level | output | 1 | Axis has stopped, held until next start |

## Verification
Two things can happen in the same cycle here: a halt command and a pulse generated by the accumulator. The bench measures the exact pulse spacing at a constant rate, then places the halt command in the cycle where the next pulse is due. The result passes only if exactly one further pulse appears and halt_level is high. A second case is the final budget pulse coinciding with the stop. The bench judges it by seeing that pulse and the stop level at the same sample, with the pulse count equal to the budget.

// File: rtl/stepramp_pkg.sv
package stepramp_pkg;

   // Command codes on cmd_code (R12)
   typedef enum logic [1:0] {
      CMD_NONE = 2'd0,
      CMD_GO   = 2'd1,
      CMD_HALT = 2'd2,
      CMD_SLOW = 2'd3
   } cmd_e;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_UP,
      PH_DOWN,
      PH_HOLD
   } ramp_ph_e;

   // Register addresses (R12)
   localparam logic [2:0] RG_DIV  = 3'd0;
   localparam logic [2:0] RG_LO   = 3'd1;
   localparam logic [2:0] RG_HI   = 3'd2;
   localparam logic [2:0] RG_ACC  = 3'd3;
   localparam logic [2:0] RG_CNT  = 3'd4;
   localparam logic [2:0] RG_RDN  = 3'd5;
   localparam logic [2:0] RG_MODE = 3'd6;

endpackage

// File: rtl/stepramp_cfg.sv
module stepramp_cfg
   import stepramp_pkg::*;
#(
   parameter int DIV_W  = 16,
   parameter int RATE_W = 13,
   parameter int ACC_W  = 10,
   parameter int CNT_W  = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [2:0]        addr,
   input  logic [CNT_W-1:0]  wdata,
   output logic [DIV_W-1:0]  div_q,
   output logic [RATE_W-1:0] lo_q,
   output logic [RATE_W-1:0] hi_q,
   output logic [ACC_W-1:0]  acc_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic [CNT_W-1:0]  rdn_q,
   output logic              scurve_q,
   output logic              preset_q
);

   generate
      if (CNT_W < DIV_W || CNT_W < RATE_W || CNT_W < ACC_W || CNT_W < 2) begin : g_bad_width
         initial $error("stepramp_cfg: CNT_W must cover every field");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q    <= '0;
         lo_q     <= '0;
         hi_q     <= '0;
         acc_q    <= '0;
         cnt_q    <= '0;
         rdn_q    <= '0;
         scurve_q <= 1'b0;
         preset_q <= 1'b0;
      end else if (we) begin
         case (addr)
            RG_DIV:  div_q <= wdata[DIV_W-1:0];
            RG_LO:   lo_q  <= wdata[RATE_W-1:0];
            RG_HI:   hi_q  <= wdata[RATE_W-1:0];
            RG_ACC:  acc_q <= wdata[ACC_W-1:0];
            RG_CNT:  cnt_q <= wdata;
            RG_RDN:  rdn_q <= wdata;
            RG_MODE: begin
               scurve_q <= wdata[0];
               preset_q <= wdata[1];
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/stepramp_pulse.sv
module stepramp_pulse #(
   parameter int DIV_W  = 16,
   parameter int RATE_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              clr,
   input  logic [DIV_W-1:0]  div,
   input  logic [RATE_W-1:0] rate,
   output logic              fire,
   output logic              step
);

   localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);

   generate
      if (DIV_W < 2 || RATE_W < 4) begin : g_bad_width
         initial $error("stepramp_pulse: widths too small");
      end
   endgenerate

   logic [DIV_W-1:0]  div_eff;
   logic [DIV_W-1:0]  pcnt;
   logic              tick;
   logic [RATE_W-1:0] phase;
   logic [RATE_W:0]   sum;

   always_comb begin
      div_eff = (div < DIV_MIN) ? DIV_MIN : div;
      tick    = (pcnt >= div_eff - DIV_W'(1));
      sum     = {1'b0, phase} + {1'b0, rate};
      fire    = en && tick && sum[RATE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt  <= '0;
         phase <= '0;
         step  <= 1'b0;
      end else begin
         step <= fire;
         if (clr) begin
            pcnt  <= '0;
            phase <= '0;
         end else begin
            pcnt <= tick ? '0 : pcnt + DIV_W'(1);
            if (en && tick) phase <= sum[RATE_W-1:0];
         end
      end
   end

   // R2: pulses are single-cycle and never back to back
   p_step_gap_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      step |=> !step);

endmodule

// File: rtl/stepramp_ramp.sv
module stepramp_ramp
   import stepramp_pkg::*;
#(
   parameter int RATE_W     = 13,
   parameter int ACC_W      = 10,
   parameter bit HAS_SCURVE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_up,
   input  logic              go_down,
   input  logic              halt,
   input  logic              scurve,
   input  logic [RATE_W-1:0] lo,
   input  logic [RATE_W-1:0] hi,
   input  logic [ACC_W-1:0]  acc_code,
   output logic [RATE_W-1:0] rate,
   output logic              settled
);

   localparam int SW = RATE_W + 1;

   generate
      if (RATE_W < 4 || ACC_W < 1) begin : g_bad_width
         initial $error("stepramp_ramp: widths too small");
      end
   endgenerate

   ramp_ph_e          ph;
   logic [RATE_W-1:0] rate_q, tgt, peak, rate_n;
   logic [SW-1:0]     span, lvl, frac, lvl_n, frac_n;
   logic              fall, fall_n, bump, tick;
   logic [ACC_W-1:0]  tcnt, acc_eff;

   always_comb begin
      peak    = (hi > lo) ? hi : lo;
      acc_eff = (acc_code == '0) ? ACC_W'(1) : acc_code;
      tick    = (tcnt >= acc_eff - ACC_W'(1));
   end

   // Per-tick rate bump: always one unit for a line; for the S-curve an
   // acceleration level climbs to the span and back, feeding a fraction
   // that releases one unit each time it passes the span.
   generate
      if (HAS_SCURVE) begin : g_scurve
         logic [SW:0]   acc_sum;
         logic [SW-1:0] nxt;
         always_comb begin
            nxt     = fall ? ((lvl == '0) ? '0 : lvl - SW'(1)) : lvl + SW'(1);
            acc_sum = {1'b0, frac} + {1'b0, nxt};
            if (scurve) begin
               bump   = (acc_sum >= {1'b0, span});
               frac_n = bump ? SW'(acc_sum - {1'b0, span}) : acc_sum[SW-1:0];
               lvl_n  = nxt;
               fall_n = fall || (nxt >= span);
            end else begin
               bump   = 1'b1;
               frac_n = frac;
               lvl_n  = lvl;
               fall_n = fall;
            end
         end
      end else begin : g_linear
         always_comb begin
            bump   = 1'b1;
            frac_n = frac;
            lvl_n  = lvl;
            fall_n = fall;
         end
      end
   endgenerate

   always_comb begin
      rate_n = (ph == PH_UP) ? rate_q + RATE_W'(bump) : rate_q - RATE_W'(bump);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph     <= PH_IDLE;
         rate_q <= '0;
         tgt    <= '0;
         span   <= '0;
         lvl    <= '0;
         frac   <= '0;
         fall   <= 1'b0;
         tcnt   <= '0;
      end else if (go_up) begin
         rate_q <= lo;
         tgt    <= peak;
         span   <= {1'b0, peak - lo};
         lvl    <= '0;
         frac   <= '0;
         fall   <= 1'b0;
         tcnt   <= '0;
         ph     <= (peak == lo) ? PH_HOLD : PH_UP;
      end else if (halt) begin
         ph <= PH_IDLE;
      end else if (go_down) begin
         tgt  <= lo;
         lvl  <= '0;
         frac <= '0;
         fall <= 1'b0;
         tcnt <= '0;
         if (rate_q > lo) begin
            span <= {1'b0, rate_q - lo};
            ph   <= PH_DOWN;
         end else begin
            rate_q <= lo;
            ph     <= PH_HOLD;
         end
      end else if (ph == PH_UP || ph == PH_DOWN) begin
         if (tick) begin
            tcnt   <= '0;
            rate_q <= rate_n;
            lvl    <= lvl_n;
            frac   <= frac_n;
            fall   <= fall_n;
            if (rate_n == tgt) ph <= PH_HOLD;
         end else begin
            tcnt <= tcnt + ACC_W'(1);
         end
      end
   end

   assign rate    = rate_q;
   assign settled = (ph == PH_HOLD);

   // R4: outside of a reload the rate never jumps by more than one unit
   p_rate_slew_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(go_up) && !$past(go_down)) |->
         (rate_q == $past(rate_q) || rate_q == $past(rate_q) + RATE_W'(1) ||
          rate_q == $past(rate_q) - RATE_W'(1)));

   // R5: while climbing the rate never falls
   p_climb_monotone_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_UP && !go_up && !go_down && !halt) |=> (rate_q >= $past(rate_q)));

endmodule

// File: rtl/stepramp_gen.sv
module stepramp_gen
   import stepramp_pkg::*;
#(
   parameter int DIV_W      = 16,
   parameter int RATE_W     = 13,
   parameter int ACC_W      = 10,
   parameter int CNT_W      = 24,
   parameter bit HAS_SCURVE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [2:0]       cfg_addr,
   input  logic [CNT_W-1:0] cfg_wdata,
   input  logic [1:0]       cmd_code,
   output logic             step_out,
   output logic             busy,
   output logic             rdn_level,
   output logic             halt_level
);

   generate
      if (CNT_W < 2) begin : g_bad_width
         initial $error("stepramp_gen: CNT_W too small");
      end
   endgenerate

   logic [DIV_W-1:0]  div_cfg;
   logic [RATE_W-1:0] lo_cfg, hi_cfg, rate;
   logic [ACC_W-1:0]  acc_cfg;
   logic [CNT_W-1:0]  cnt_cfg, rdn_cfg, rem_q;
   logic              scurve_cfg, preset_cfg;
   logic              fire, settled;
   logic              run_q, pre_q, slow_q, rdn_q, halt_q;
   logic              go_cmd, halt_cmd, slow_cmd, zero_load;
   logic              last_pulse, rd_hit, stop_now;
   cmd_e              cmd;

   stepramp_cfg #(
      .DIV_W(DIV_W), .RATE_W(RATE_W), .ACC_W(ACC_W), .CNT_W(CNT_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .div_q(div_cfg), .lo_q(lo_cfg), .hi_q(hi_cfg), .acc_q(acc_cfg),
      .cnt_q(cnt_cfg), .rdn_q(rdn_cfg), .scurve_q(scurve_cfg), .preset_q(preset_cfg)
   );

   always_comb begin
      cmd        = cmd_e'(cmd_code);
      go_cmd     = (cmd == CMD_GO);
      halt_cmd   = (cmd == CMD_HALT) && run_q;
      slow_cmd   = (cmd == CMD_SLOW) && run_q;
      zero_load  = preset_cfg && (cnt_cfg == '0);
      last_pulse = fire && pre_q && (rem_q == CNT_W'(1));
      rd_hit     = run_q && pre_q && !rdn_q && (rem_q <= rdn_cfg);
      stop_now   = run_q && !go_cmd && (last_pulse || halt_cmd || (slow_q && settled));
   end

   stepramp_ramp #(
      .RATE_W(RATE_W), .ACC_W(ACC_W), .HAS_SCURVE(HAS_SCURVE)
   ) u_ramp (
      .clk(clk), .rst_n(rst_n),
      .go_up(go_cmd && !zero_load),
      .go_down(!go_cmd && (slow_cmd || rd_hit)),
      .halt(stop_now),
      .scurve(scurve_cfg), .lo(lo_cfg), .hi(hi_cfg), .acc_code(acc_cfg),
      .rate(rate), .settled(settled)
   );

   stepramp_pulse #(
      .DIV_W(DIV_W), .RATE_W(RATE_W)
   ) u_pulse (
      .clk(clk), .rst_n(rst_n), .en(run_q), .clr(go_cmd),
      .div(div_cfg), .rate(rate), .fire(fire), .step(step_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         pre_q  <= 1'b0;
         slow_q <= 1'b0;
         rdn_q  <= 1'b0;
         halt_q <= 1'b0;
         rem_q  <= '0;
      end else if (go_cmd) begin
         run_q  <= !zero_load;
         halt_q <= zero_load;
         rdn_q  <= 1'b0;
         slow_q <= 1'b0;
         pre_q  <= preset_cfg;
         rem_q  <= cnt_cfg;
      end else if (run_q) begin
         if (fire && pre_q) rem_q <= rem_q - CNT_W'(1);
         if (stop_now) begin
            run_q  <= 1'b0;
            halt_q <= 1'b1;
            slow_q <= 1'b0;
         end else begin
            if (slow_cmd) slow_q <= 1'b1;
            if (rd_hit)   rdn_q  <= 1'b1;
         end
      end
   end

   assign busy       = run_q;
   assign rdn_level  = rdn_q;
   assign halt_level = halt_q;

   // R6: stop level and motion are exclusive
   p_halt_idle_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      halt_q |-> !run_q);

   // R6: a budgeted move never runs with nothing left to emit
   p_budget_live_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && pre_q) |-> (rem_q != '0));

   // R7: ramp-down level only exists for budgeted moves
   p_rdn_budget_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      rdn_q |-> pre_q);

   // R8: every pulse was produced while the axis was moving
   p_step_moving_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      step_out |-> $past(run_q));

endmodule

// File: tb/stepramp_gen_test.sv
module stepramp_gen_test;

   localparam int CNT_W = 24;
   localparam int WD    = 190000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_we = 1'b0;
   logic [2:0]       cfg_addr = '0;
   logic [CNT_W-1:0] cfg_wdata = '0;
   logic [1:0]       cmd_code = '0;
   logic             step_out, busy, rdn_level, halt_level;

   int tests = 0;
   int failed = 0;
   int steps = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   stepramp_gen uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cmd_code(cmd_code), .step_out(step_out),
      .busy(busy), .rdn_level(rdn_level), .halt_level(halt_level)
   );

   task automatic tick();
      @(negedge clk);
      if (step_out) steps++;
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         failed++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // R12: address map 0 div, 1 lo, 2 hi, 3 acc, 4 budget, 5 threshold, 6 mode
   task automatic wr(input logic [2:0] a, input int d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = CNT_W'(d);
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic cmd(input logic [1:0] c);
      cmd_code = c;
      tick();
      cmd_code = 2'd0;
   endtask

   task automatic wait_step();
      tick();
      while (!step_out) tick();
   endtask

   task automatic period(output int p);
      wait_step();
      p = 0;
      do begin tick(); p++; end while (!step_out);
   endtask

   task automatic setup(input int dv, input int lo, input int hi, input int ac, input int md);
      wr(3'd0, dv); wr(3'd1, lo); wr(3'd2, hi); wr(3'd3, ac); wr(3'd6, md);
   endtask

   initial begin
      repeat (WD) @(posedge clk);
      if (!done) begin
         tests++; failed++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  [TB] %0d tests run, %0d failed", tests, failed);
         $finish;
      end
   end

   initial begin
      int p, s0, n, exp_n;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      tick();
      // R1
      chk(!step_out && !busy && !rdn_level && !halt_level, "R1 reset outputs",
          {step_out, busy, rdn_level, halt_level}, 0);

      // R10: halt while idle does nothing
      cmd(2'd2);
      repeat (3) tick();
      chk(!halt_level && !busy, "R10 idle halt ignored", {halt_level, busy}, 0);

      // R3 / R2: flat at start rate 2048, div 2 -> 8 cycles
      setup(2, 2048, 2048, 4, 0);
      cmd(2'd1);
      chk(busy == 1'b1, "R3 busy after start", busy, 1);
      period(p);
      chk(p == 8, "R2 R3 flat start-rate period", p, 8);

      // R8: halt landing on a pulse cycle still lets that pulse out
      wait_step();
      repeat (7) tick();
      s0 = steps;
      cmd(2'd2);
      repeat (20) tick();
      chk(steps - s0 == 1, "R8 coincident pulse emitted once", steps - s0, 1);
      chk(halt_level && !busy, "R8 halt level", {halt_level, busy}, 2);

      // R3: run rate below start rate keeps start rate
      setup(2, 2048, 1024, 4, 0);
      cmd(2'd1);
      chk(!halt_level, "R10 start clears halt level", halt_level, 0);
      repeat (40) tick();
      period(p);
      chk(p == 8, "R3 run below start", p, 8);
      cmd(2'd2);

      // R2: divisor 3 and divisor 1 (acts as 2), R12 register 0
      setup(3, 4096, 4096, 4, 0);
      cmd(2'd1);
      period(p);
      chk(p == 6, "R2 R12 divisor 3", p, 6);
      cmd(2'd2);
      setup(1, 4096, 4096, 4, 0);
      cmd(2'd1);
      period(p);
      chk(p == 4, "R2 divisor below 2", p, 4);
      cmd(2'd2);
      repeat (5) tick();

      // R4 / R9: linear ramp 2048 -> 4096, acc 4
      setup(2, 2048, 4096, 4, 0);
      cmd(2'd1);
      repeat (9000) tick();
      period(p);
      chk(p == 4, "R4 linear reaches run rate", p, 4);
      cmd(2'd3);
      n = 1;
      while (!halt_level && n < 40000) begin tick(); n++; end
      exp_n = 2048 * 4;
      chk(n >= exp_n - 16 && n <= exp_n + 16, "R4 R9 linear decel duration", n, exp_n);
      chk(!busy && halt_level, "R9 stopped after slow-down", {busy, halt_level}, 1);

      // R5: S-curve takes twice as long
      setup(2, 2048, 4096, 4, 1);
      cmd(2'd1);
      repeat (17000) tick();
      period(p);
      chk(p == 4, "R5 S-curve reaches run rate", p, 4);
      cmd(2'd3);
      n = 1;
      while (!halt_level && n < 60000) begin tick(); n++; end
      exp_n = 2 * 2048 * 4;
      chk(n >= exp_n - 16 && n <= exp_n + 16, "R5 S-curve decel duration", n, exp_n);

      // R6 / R7: budget 8000, threshold 3500, linear
      setup(2, 2048, 4096, 4, 2);
      wr(3'd4, 8000); wr(3'd5, 3500);
      s0 = steps;
      cmd(2'd1);
      n = 0;
      while (!rdn_level && n < 60000) begin tick(); n++; end
      chk(steps - s0 == 4500, "R7 pulses at ramp-down", steps - s0, 4500);
      n = 0;
      while (!halt_level && n < 60000) begin tick(); n++; end
      chk(step_out == 1'b1, "R6 last pulse with stop level", step_out, 1);
      chk(steps - s0 == 8000, "R6 budget pulse count", steps - s0, 8000);
      repeat (50) tick();
      chk(steps - s0 == 8000 && !busy, "R6 nothing after budget", steps - s0, 8000);
      chk(rdn_level == 1'b1, "R7 ramp-down level held", rdn_level, 1);
      cmd(2'd1);
      chk(!rdn_level && !halt_level, "R10 start clears levels", {rdn_level, halt_level}, 0);
      cmd(2'd2);

      // R11: zero budget
      wr(3'd4, 0);
      s0 = steps;
      cmd(2'd1);
      chk(halt_level && !busy, "R11 zero budget stops at once", {halt_level, busy}, 2);
      repeat (20) tick();
      chk(steps == s0, "R11 zero budget no pulses", steps - s0, 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
   end

endmodule